// File: doc/BRIEF.md
# DMA Stream Control Register

This block holds the 32-bit configuration and control word for one DMA stream. Software writes the whole word through a simple write strobe and reads it back on a combinational read bus. The word carries a channel number, a burst code for each side, a buffer selector, double-buffer and priority settings, data sizes, increment and circular controls, direction, flow control, interrupt enables and the stream enable in bit 0.

A transfer engine uses the decoded outputs: the channel number, the beat count for each side, the buffer in use and the enable. It returns two signals. One is a level that says the stream runs without a FIFO. The other is a one-cycle pulse sent each time a buffer completes. While the stream runs, the channel and burst fields and the buffer selector are locked against software writes. The engine's FIFO-less level clears both burst codes. In double-buffer operation the buffer selector becomes a status flag that the hardware flips.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After reset, every read bit is 0 and every decoded output is at its zero-code value (channel 0, target 0, enable 0, beat counts 1).
- R2: A write always loads bits [18:0] from the write data at the clock edge. Bit 18 is double-buffer, bits [17:1] are the other settings and bit 0 is enable.
- R3: A write while enable (bit 0) reads 0 loads the channel field [27:25], the memory burst field [24:23], the peripheral burst field [22:21] and the target bit [19].
- R4: A write while enable reads 1 leaves bits [27:21] and bit 19 unchanged.
- R5: At any edge where enable reads 1 and the FIFO-less input is 1, both burst fields become 00. With enable at 0 the FIFO-less input has no effect.
- R6: At an edge where enable, double-buffer (bit 18) and the buffer-complete pulse are all 1, the target bit inverts.
- R7: A buffer-complete pulse changes nothing when enable or double-buffer is 0.
- R8: Bits [31:28] and bit 20 read 0 whatever value was written to them.
- R9: The burst codes decode to beats as 00=1, 01=4, 10=8 and 11=16. The channel output is bits [27:25], the target output is bit 19 and the enable output is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| direct_mode_i | input | 1 | Engine runs the stream without a FIFO |
| buf_done_i | input | 1 | One-cycle pulse when a buffer completes |
| chan_o | output | 3 | Selected channel |
| mem_beats_o | output | 5 | Memory-side beats per burst |
| per_beats_o | output | 5 | Peripheral-side beats per burst |
| target_o | output | 1 | Buffer in use (0 or 1) |
| enable_o | output | 1 | Stream enable |

## Verification
The bench builds the block with its default field widths and a 5-bit beat output. With that width every burst code, including the 16-beat code, can be seen at the ports. A single sequence first fills the locked fields while the stream is idle and then enables it. It then tries to overwrite those fields and drives buffer-complete pulses with double-buffer both off and on. It also raises the FIFO-less input in both enable states, and brings out each effect on the read bus and the decoded outputs.

// File: rtl/dma_scr_pkg.sv
package dma_scr_pkg;
  localparam int REG_W   = 32;
  localparam int CHAN_W  = 3;
  localparam int BURST_W = 2;
  localparam int BEAT_W  = 5;
  localparam int FREE_W  = 19;
  localparam int CHAN_LSB = 25;
  localparam int MB_LSB   = 23;
  localparam int PB_LSB   = 21;
  localparam int TGT_BIT  = 19;
  localparam int DBL_BIT  = 18;
  localparam int EN_BIT   = 0;

  // 00 -> 1 beat, otherwise 2 << code (4, 8, 16)
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [BURST_W-1:0] code);
    if (code == '0) return BEAT_W'(1);
    return BEAT_W'(2) << code;
  endfunction
endpackage

// File: rtl/scr_locked_field.sv
module scr_locked_field #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         force_clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (force_clr) q <= '0;
    else if (load)      q <= d;
  end
endmodule

// File: rtl/scr_target_flag.sv
module scr_target_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_load,
  input  logic sw_val,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (flip)    q <= ~q;
    else if (sw_load) q <= sw_val;
  end
endmodule

// File: rtl/scr_beat_decode.sv
module scr_beat_decode
  import dma_scr_pkg::*;
(
  input  logic [BURST_W-1:0] code,
  output logic [BEAT_W-1:0]  beats
);
  assign beats = burst_beats(code);
endmodule

// File: rtl/dma_stream_ctrl.sv
module dma_stream_ctrl
  import dma_scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             direct_mode_i,
  input  logic             buf_done_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic [BEAT_W-1:0] mem_beats_o,
  output logic [BEAT_W-1:0] per_beats_o,
  output logic             target_o,
  output logic             enable_o
);
  localparam int NSIDE = 2;

  logic [FREE_W-1:0]  free_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [BURST_W-1:0] burst_q [NSIDE];
  logic [BEAT_W-1:0]  beats   [NSIDE];
  logic               tgt_q;

  // named events for the checker
  logic en_q;
  logic sw_open;
  logic burst_clear;
  logic tgt_flip;

  assign en_q        = free_q[EN_BIT];
  assign sw_open     = wr_en && !en_q;
  assign burst_clear = en_q && direct_mode_i;
  assign tgt_flip    = en_q && free_q[DBL_BIT] && buf_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     free_q <= '0;
    else if (wr_en) free_q <= wr_data[FREE_W-1:0];
  end

  scr_locked_field #(.W(CHAN_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .load(sw_open), .force_clr(1'b0),
    .d(wr_data[CHAN_LSB +: CHAN_W]), .q(chan_q)
  );

  localparam int SIDE_LSB [NSIDE] = '{MB_LSB, PB_LSB};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    scr_locked_field #(.W(BURST_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(sw_open), .force_clr(burst_clear),
      .d(wr_data[SIDE_LSB[s] +: BURST_W]), .q(burst_q[s])
    );
    scr_beat_decode u_dec (.code(burst_q[s]), .beats(beats[s]));
  end

  scr_target_flag u_tgt (
    .clk(clk), .rst_n(rst_n), .sw_load(sw_open),
    .sw_val(wr_data[TGT_BIT]), .flip(tgt_flip), .q(tgt_q)
  );

  assign rd_data = {4'b0000, chan_q, burst_q[0], burst_q[1], 1'b0, tgt_q, free_q};

  assign chan_o      = chan_q;
  assign mem_beats_o = beats[0];
  assign per_beats_o = beats[1];
  assign target_o    = tgt_q;
  assign enable_o    = en_q;
endmodule

// File: rtl/scr_ctrl_chk.sv
module scr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        direct_mode_i,
  input logic        buf_done_i,
  input logic [4:0]  mem_beats_o,
  input logic [4:0]  per_beats_o,
  input logic        target_o,
  input logic        enable_o,
  input logic        tgt_flip,
  input logic        burst_clear
);
  a_r2_free_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[18:0] == $past(wr_data[18:0]));

  a_r3_open_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !enable_o) |=> (rd_data[27:21] == $past(wr_data[27:21])) &&
                             (target_o == $past(wr_data[19])));

  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enable_o && !direct_mode_i) |=> $stable(rd_data[27:21]));

  a_r4_tgt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enable_o && !buf_done_i) |=> $stable(target_o));

  a_r5_direct_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o && direct_mode_i) |=> rd_data[24:21] == 4'b0000);

  a_r5_clear_event: assert property (@(posedge clk) disable iff (!rst_n)
    burst_clear |-> (enable_o && direct_mode_i));

  a_r6_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o && rd_data[18] && buf_done_i) |=> target_o != $past(target_o));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_flip && !(wr_en && !enable_o)) |=> $stable(target_o));

  a_r9_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_beats_o) && $onehot0(per_beats_o) &&
    mem_beats_o != 5'd0 && per_beats_o != 5'd0 && mem_beats_o != 5'd2);
endmodule

bind dma_stream_ctrl scr_ctrl_chk u_chk (.*);

// File: tb/dma_stream_ctrl_test.sv
module dma_stream_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        direct_mode_i = 1'b0;
  logic        buf_done_i = 1'b0;
  logic [2:0]  chan_o;
  logic [4:0]  mem_beats_o, per_beats_o;
  logic        target_o, enable_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_stream_ctrl uut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic        direct;
    logic        done;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'hFFF0_0000, 1'b0, 1'b0, 32'h0FE0_0000},
    '{1'b1, 32'h04CF_0000, 1'b0, 1'b0, 32'h04CF_0000},
    '{1'b1, 32'h04CF_0001, 1'b0, 1'b0, 32'h04CF_0001},
    '{1'b1, 32'h0E20_8001, 1'b0, 1'b0, 32'h04C8_8001},
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h04C8_8001},
    '{1'b1, 32'h0004_8001, 1'b0, 1'b0, 32'h04CC_8001},
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h04C4_8001},
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h04CC_8001},
    '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h040C_8001},
    '{1'b1, 32'h0000_0000, 1'b1, 1'b1, 32'h0400_0000},
    '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0400_0000},
    '{1'b1, 32'h0180_0000, 1'b1, 1'b0, 32'h0180_0000}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R3 R8";
      1: return "R3";
      2, 5: return "R2";
      3: return "R4";
      4, 10: return "R7";
      6, 7, 9: return "R6";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [4:0] beats_of(logic [1:0] c);
    case (c)
      2'b00: return 5'd1;
      2'b01: return 5'd4;
      2'b10: return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic [31:0] exp);
    chk(req, rd_data, exp);
    chk("R9 chan", 32'(chan_o), 32'(exp[27:25]));
    chk("R9 mem beats", 32'(mem_beats_o), 32'(beats_of(exp[24:23])));
    chk("R9 per beats", 32'(per_beats_o), 32'(beats_of(exp[22:21])));
    chk("R9 target", 32'(target_o), 32'(exp[19]));
    chk("R9 enable", 32'(enable_o), 32'(exp[0]));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].wr;
      wr_data = VEC[i].data;
      direct_mode_i = VEC[i].direct;
      buf_done_i = VEC[i].done;
      @(negedge clk);
      wr_en = 1'b0;
      direct_mode_i = 1'b0;
      buf_done_i = 1'b0;
      chk_all(tag_of(i), VEC[i].exp);
    end
    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", 32'h0);
    rst_n = 1'b1;
    // R3: target and enable written together while idle
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'h0008_0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk_all("R3 target preset", 32'h0008_0001);
    // R4: target write ignored while enabled
    wr_en = 1'b1;
    wr_data = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk_all("R4 target locked", 32'h0008_0001);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule